// File: doc/BRIEF.md
# Bi-Mode Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two pattern tables of 2-bit saturating counters. One table serves branches that lean toward taken, the other branches that lean toward not-taken. A third table, the chooser, is indexed by address bits alone and decides which pattern table gives the answer for a branch. Grouping branches by their lean means that two branches sharing a pattern entry usually push it the same way.

Both pattern tables are indexed by the fetch address bits XORed with the global history. The block holds that history itself. Each prediction shifts the guessed direction into the history. The caller keeps the history value that came out with the prediction and returns it, together with the resolved outcome, on the update port. From that snapshot the block re-derives the chooser's pick and the picked table's guess. It trains only the picked table. If the picked table guessed wrong, it rebuilds the history from the snapshot with the true outcome appended.

Top module: `bimode_predictor`

## Requirements
- R1: After reset every taken-table counter is 2 (weakly taken), every not-taken-table counter is 1 (weakly not taken), every chooser counter is 2, and the history is 0. So every address predicts taken and `pred_hist_o` reads 0.
- R2: Pattern tables are indexed by `pc[PC_LSB +: HIST_W] ^ history`, and the chooser is indexed by `pc[PC_LSB +: CH_W]`.
- R3: The prediction is the MSB of the counter in the taken table when the chooser counter's MSB is 1, and the MSB of the counter in the not-taken table otherwise.
- R4: On an update, only the pattern table that the chooser picks is trained: its counter moves one step toward the outcome and saturates at 0 and 3. The other table keeps its value.
- R5: The chooser counter is left alone when its pick (MSB) disagrees with the outcome but the picked table guessed right. In every other case it moves one step toward the outcome (taken = up), saturating at 0 and 3.
- R6: When `pred_valid_i` is high and no repair happens, the history shifts left by one and the predicted bit enters at bit 0.
- R7: An update is a mispredict when the picked table's MSB, read with the update snapshot, differs from the outcome. On a mispredict the history becomes `{upd_hist_i[HIST_W-2:0], upd_taken_i}`, and this takes priority over a shift in the same cycle.
- R8: `pred_taken_o` and `pred_hist_o` follow `pred_pc_i` combinationally in the same cycle. The effects of an update show from the next clock edge on.
- R9: With both valid inputs low, no table and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| pred_valid_i | input | 1 | a prediction is taken this cycle; the history shifts |
| pred_pc_i | input | PC_W | fetch address of the branch being predicted |
| pred_taken_o | output | 1 | predicted direction, 1 = taken |
| pred_hist_o | output | HIST_W | history used for this prediction; the caller keeps it for the update |
| upd_valid_i | input | 1 | a resolved branch is presented |
| upd_pc_i | input | PC_W | address of the resolved branch |
| upd_taken_i | input | 1 | resolved outcome |
| upd_hist_i | input | HIST_W | history snapshot saved at prediction time |

## Verification
A vector table walks a few branch addresses through mixed outcome runs. Alternating predictions and updates separate the shifted history from the repaired one, and the trained entry from the untrained one. Directed sequences do three things. They drive one address not-taken right after reset to see the chooser hand the branch to the not-taken table. They alias a second address onto an already-trained entry so that the chooser is wrong while its table is right, which separates the chooser-hold rule from plain training. They repeat one outcome to reach saturation. Further cycles present a prediction and a mispredicting update together to show that the repair wins. Idle cycles with a changing address show that the state does not move.

// File: rtl/bimode_pkg.sv
package bimode_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'd0;
  localparam ctr_t CTR_WNT = 2'd1;
  localparam ctr_t CTR_WT  = 2'd2;
  localparam ctr_t CTR_ST  = 2'd3;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == CTR_ST) ? c : ctr_t'(c + 2'd1);
    return (c == CTR_SNT) ? c : ctr_t'(c - 2'd1);
  endfunction
endpackage

// File: rtl/bimode_ctr_table.sv
module bimode_ctr_table
  import bimode_pkg::*;
#(
  parameter int unsigned IDX_W   = 6,
  parameter ctr_t        RST_VAL = CTR_WT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_idx_i,
  output ctr_t             ra_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output ctr_t             rb_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             wup_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  ctr_t [DEPTH-1:0] mem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem <= {DEPTH{RST_VAL}};
    else if (we_i) mem[widx_i] <= ctr_step(mem[widx_i], wup_i);
  end

  assign ra_o = mem[ra_idx_i];
  assign rb_o = mem[rb_idx_i];

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem)); // R9
  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wup_i && mem[widx_i] == CTR_ST) |=> mem[$past(widx_i)] == CTR_ST); // R4
  AST_SAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wup_i && mem[widx_i] == CTR_SNT) |=> mem[$past(widx_i)] == CTR_SNT); // R4
endmodule

// File: rtl/bimode_ghr.sv
module bimode_ghr #(
  parameter int unsigned HIST_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              shift_bit_i,
  input  logic              fix_en_i,
  input  logic [HIST_W-1:0] fix_hist_i,
  input  logic              fix_bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (fix_en_i)   hist_q <= {fix_hist_i[HIST_W-2:0], fix_bit_i};
    else if (shift_en_i) hist_q <= {hist_q[HIST_W-2:0], shift_bit_i};
  end

  assign hist_o = hist_q;

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !fix_en_i) |=>
      (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])) && (hist_q[0] == $past(shift_bit_i))); // R6
  AST_REPAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_en_i |=> hist_q == {$past(fix_hist_i[HIST_W-2:0]), $past(fix_bit_i)}); // R7
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !fix_en_i) |=> $stable(hist_q)); // R9
endmodule

// File: rtl/bimode_predictor.sv
module bimode_predictor
  import bimode_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned PC_LSB = 2,
  parameter int unsigned HIST_W = 6,
  parameter int unsigned CH_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_valid_i,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [HIST_W-1:0] upd_hist_i
);
  localparam int unsigned IDX_SPAN = (HIST_W > CH_W) ? HIST_W : CH_W;

  if (PC_LSB + IDX_SPAN > PC_W) begin : g_bad_cfg
    initial $error("index bits exceed PC width");
  end

  logic [HIST_W-1:0] ghr;
  logic [HIST_W-1:0] p_didx, u_didx;
  logic [CH_W-1:0]   p_cidx, u_cidx;
  ctr_t p_t, u_t, p_nt, u_nt, p_ch, u_ch;
  logic u_use_t, u_sel_pred, u_mispred;
  logic t_we, nt_we, ch_we;

  // gshare hashing on the pattern tables, plain address on the chooser
  assign p_didx = pred_pc_i[PC_LSB +: HIST_W] ^ ghr;
  assign u_didx = upd_pc_i[PC_LSB +: HIST_W] ^ upd_hist_i;
  assign p_cidx = pred_pc_i[PC_LSB +: CH_W];
  assign u_cidx = upd_pc_i[PC_LSB +: CH_W];

  bimode_ctr_table #(.IDX_W(HIST_W), .RST_VAL(CTR_WT)) u_taken_tbl (
    .clk_i, .rst_ni,
    .ra_idx_i(p_didx), .ra_o(p_t),
    .rb_idx_i(u_didx), .rb_o(u_t),
    .we_i(t_we), .widx_i(u_didx), .wup_i(upd_taken_i)
  );

  bimode_ctr_table #(.IDX_W(HIST_W), .RST_VAL(CTR_WNT)) u_ntaken_tbl (
    .clk_i, .rst_ni,
    .ra_idx_i(p_didx), .ra_o(p_nt),
    .rb_idx_i(u_didx), .rb_o(u_nt),
    .we_i(nt_we), .widx_i(u_didx), .wup_i(upd_taken_i)
  );

  bimode_ctr_table #(.IDX_W(CH_W), .RST_VAL(CTR_WT)) u_choice_tbl (
    .clk_i, .rst_ni,
    .ra_idx_i(p_cidx), .ra_o(p_ch),
    .rb_idx_i(u_cidx), .rb_o(u_ch),
    .we_i(ch_we), .widx_i(u_cidx), .wup_i(upd_taken_i)
  );

  assign pred_taken_o = p_ch[1] ? p_t[1] : p_nt[1];
  assign pred_hist_o  = ghr;

  assign u_use_t    = u_ch[1];
  assign u_sel_pred = u_use_t ? u_t[1] : u_nt[1];
  assign u_mispred  = upd_valid_i && (u_sel_pred != upd_taken_i);

  assign t_we  = upd_valid_i && u_use_t;
  assign nt_we = upd_valid_i && !u_use_t;
  // chooser holds when it was wrong but its pick still got the branch right
  assign ch_we = upd_valid_i && !((u_use_t != upd_taken_i) && (u_sel_pred == upd_taken_i));

  bimode_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk_i, .rst_ni,
    .shift_en_i(pred_valid_i), .shift_bit_i(pred_taken_o),
    .fix_en_i(u_mispred), .fix_hist_i(upd_hist_i), .fix_bit_i(upd_taken_i),
    .hist_o(ghr)
  );

  AST_UNPICKED_NT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && u_use_t) |=> u_ntaken_tbl.mem[$past(u_didx)] == $past(u_nt)); // R4
  AST_UNPICKED_T_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !u_use_t) |=> u_taken_tbl.mem[$past(u_didx)] == $past(u_t)); // R4
  AST_CHOICE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && (u_use_t != upd_taken_i) && (u_sel_pred == upd_taken_i))
      |=> u_choice_tbl.mem[$past(u_cidx)] == $past(u_ch)); // R5
  AST_PRED_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(pred_taken_o)); // R3
endmodule

// File: tb/bimode_predictor_bench.sv
module bimode_predictor_bench;
  localparam int H  = 6;
  localparam int NV = 20;
  localparam logic [31:0] VPC [NV] = '{
    32'h100, 32'h104, 32'h100, 32'h108, 32'h100, 32'h140, 32'h104, 32'h100,
    32'h108, 32'h140, 32'h100, 32'h104, 32'h1fc, 32'h100, 32'h108, 32'h1fc,
    32'h140, 32'h100, 32'h104, 32'h100};
  localparam logic VTK [NV] = '{
    1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
    1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
    1'b1, 1'b0, 1'b1, 1'b0};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pred_valid_i = 1'b0, upd_valid_i = 1'b0, upd_taken_i = 1'b0;
  logic [31:0] pred_pc_i = '0, upd_pc_i = '0;
  logic [H-1:0] upd_hist_i = '0;
  logic pred_taken_o;
  logic [H-1:0] pred_hist_o;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [1:0] mt [64];
  logic [1:0] mn [64];
  logic [1:0] mc [64];
  logic [H-1:0] mg;

  always #5 clk_i = ~clk_i;

  bimode_predictor u_bimode_predictor (
    .clk_i, .rst_ni, .pred_valid_i, .pred_pc_i, .pred_taken_o, .pred_hist_o,
    .upd_valid_i, .upd_pc_i, .upd_taken_i, .upd_hist_i
  );

  function automatic logic [1:0] sat(logic [1:0] c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic mpred(logic [31:0] pc);
    logic [5:0] ci, di;
    ci = pc[7:2]; di = ci ^ mg;
    return mc[ci][1] ? mt[di][1] : mn[di][1];
  endfunction

  task automatic mstep(logic pv, logic [31:0] ppc, logic uv, logic [31:0] upc,
                       logic ut, logic [H-1:0] uh);
    logic p, fix, use_t, sp;
    logic [5:0] ci, di;
    p = mpred(ppc); fix = 0;
    if (uv) begin
      ci = upc[7:2]; di = ci ^ uh;
      use_t = mc[ci][1];
      sp = use_t ? mt[di][1] : mn[di][1];
      fix = (sp != ut);
      if (use_t) mt[di] = sat(mt[di], ut); else mn[di] = sat(mn[di], ut);
      if (!((use_t != ut) && (sp == ut))) mc[ci] = sat(mc[ci], ut);
    end
    if (fix) mg = {uh[H-2:0], ut};
    else if (pv) mg = {mg[H-2:0], p};
  endtask

  task automatic chk(logic [H-1:0] act, logic [H-1:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; pred_valid_i = 0; upd_valid_i = 0;
    for (int i = 0; i < 64; i++) begin mt[i] = 2'd2; mn[i] = 2'd1; mc[i] = 2'd2; end
    mg = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  // drive one cycle, compare combinational outputs against the model, advance model at the edge
  task automatic step(logic pv, logic [31:0] ppc, logic uv, logic [31:0] upc,
                      logic ut, logic [H-1:0] uh, string tag);
    @(negedge clk_i);
    pred_valid_i = pv; pred_pc_i = ppc;
    upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut; upd_hist_i = uh;
    #1;
    chk(H'(pred_taken_o), H'(mpred(ppc)), {tag, " pred"});
    chk(pred_hist_o, mg, {tag, " hist"});
    @(posedge clk_i);
    mstep(pv, ppc, uv, upc, ut, uh);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [H-1:0] snap;
    do_reset();

    // R1: fixed reset values
    @(negedge clk_i); pred_pc_i = 32'h40; #1;
    chk(H'(pred_taken_o), H'(1'b1), "R1 reset pred pc40");
    chk(pred_hist_o, '0, "R1 reset hist");
    pred_pc_i = 32'h1fc; #1;
    chk(H'(pred_taken_o), H'(1'b1), "R1 reset pred pc1fc");

    // R8 R4 R5: one not-taken update moves the branch to the not-taken table next cycle
    step(0, 32'h40, 1, 32'h40, 1'b0, '0, "R8 first update");
    @(negedge clk_i); pred_valid_i = 0; upd_valid_i = 0; pred_pc_i = 32'h40; #1;
    chk(H'(pred_taken_o), H'(1'b0), "R8 R5 pred after update");
    chk(pred_hist_o, '0, "R7 repaired hist");

    // vector walk: predict, then resolve with the saved snapshot
    for (int i = 0; i < NV; i++) begin
      snap = mg;
      step(1, VPC[i], 0, '0, 1'b0, '0, "R2 R3 R6 vec");
      step(0, VPC[i], 1, VPC[i], VTK[i], snap, "R4 R5 R7 vec");
    end

    // R5: chooser wrong, picked table right -> chooser holds
    do_reset();
    step(0, 32'h40, 1, 32'h40, 1'b0, 6'd1, "R5 alias setup");
    step(0, 32'h4c, 1, 32'h4c, 1'b0, 6'd2, "R5 chooser hold");
    step(0, 32'h4c, 1, 32'h4c, 1'b1, 6'd2, "R5 after hold");
    step(0, 32'h4c, 0, '0, 1'b0, '0, "R5 observe");

    // R4: saturation under repeated outcomes
    for (int k = 0; k < 5; k++) step(0, 32'h80, 1, 32'h80, 1'b1, 6'd0, "R4 sat up");
    for (int k = 0; k < 6; k++) step(0, 32'h80, 1, 32'h80, 1'b0, 6'd0, "R4 sat down");
    step(0, 32'h80, 0, '0, 1'b0, '0, "R4 observe");

    // R7: prediction and mispredicting update together, repair wins
    step(1, 32'h100, 1, 32'h80, 1'b1, 6'h2a, "R7 priority");
    step(1, 32'h104, 0, '0, 1'b0, '0, "R6 R7 after priority");

    // R9: idle cycles with a moving address
    for (int k = 0; k < 4; k++) step(0, 32'h100 + 32'(k * 4), 0, 32'h80, 1'b1, '1, "R9 idle");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule